// File: doc/BRIEF.md
# Interrupt Pending and Exception Entry Unit

This unit sits next to a simple in-order CPU core and turns up to 32 level-sensitive external interrupt lines into a precise exception entry. Every line that is high at a rising clock edge sets its bit in a sticky pending register. The pending register is ANDed with a mask register and gated by a live global enable bit. The result is examined only when the core reports that an instruction has just retired, so an entry never splits an instruction.

When an entry is taken, the unit raises a single-cycle pulse. The pulse carries the target vector, which is the exception base plus the interrupt exception number times a 32-byte slot. It also tells the core to write the current PC into general register 30 as the return address. On the same clock edge the enable register is loaded with binary 10: the live enable is cleared and a saved copy is set, which blocks nesting.

Software reaches the enable, mask, pending and base registers through a simple CSR read and write port. Pending bits are cleared by writing ones to them. The check runs on every retired instruction, so a bit that became pending while interrupts were off is taken as soon as software enables it. No new edge on the line is needed.

Top module: `irq_entry_unit`

## Requirements
- R1: After a synchronous active-low reset, the enable, mask, pending and base registers all read 0 and take_interrupt is low.
- R2: A line n that is high at a rising clock edge sets pending bit n, and the bit reads 1 from the next cycle on. When the line falls the bit stays set (sticky).
- R3: A CSR write to the pending register (csr_addr 2) clears every bit whose write-data bit is 1 and leaves the other bits as they are. If the line for a bit is high in the same cycle, the set wins and the bit stays 1.
- R4: take_interrupt is high in the same cycle only when instr_retire is 1, enable bit 0 (csr_addr 0) is 1, and the AND of mask (csr_addr 1) and pending is nonzero. A masked pending bit never causes an entry.
- R5: With all other conditions met, no entry happens while instr_retire is 0. The entry happens on the first cycle in which instr_retire is 1.
- R6: During an entry, vector_pc equals the base register (csr_addr 3) plus EXC_ID*32, which is base + 0xC0 for the default EXC_ID of 6. Writes to the base register force its low 8 bits to 0.
- R7: During an entry, save_pc_to_r30 is 1 and ret_pc equals cur_pc.
- R8: After an entry edge the enable register reads 2 (bit 1 saved-enable = 1, bit 0 live-enable = 0). An entry takes priority over a CSR write to the enable register in the same cycle.
- R9: A pending bit whose line has already dropped still causes an entry once the matching mask bit and enable bit 0 are written to 1 and an instruction retires.
- R10: take_interrupt is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 32 | Level-sensitive interrupt lines, line n maps to pending bit n |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 2 | CSR select: 0 enable, 1 mask, 2 pending, 3 base |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for csr_addr (combinational) |
| instr_retire | input | 1 | Core reports an instruction boundary this cycle |
| cur_pc | input | 32 | PC of the next instruction at the boundary |
| take_interrupt | output | 1 | Single-cycle exception entry pulse |
| vector_pc | output | 32 | Redirect target during an entry |
| save_pc_to_r30 | output | 1 | Write ret_pc into general register 30 |
| ret_pc | output | 32 | Return address to be saved |

## Verification
The bench lowers a line before interrupts are enabled and then expects an entry after the enable and mask writes. A design that cleared pending bits with the line, or that checked only on edges, would never enter. It holds a line high while writing a one to its pending bit, which catches a clear that overrides the set. It raises enable-register writes and retirements in the same cycle as an entry and holds retirement high across two cycles. A design that lost the saved-enable pattern or stretched the pulse would then read back the wrong enable value or show a second pulse. It also checks masked-only pending bits, an unaligned base write and both edge lines (0 and 31), which exposes wrong vector arithmetic or a misrouted line.

// File: rtl/irq_pkg.sv
// Shared constants and types for the interrupt entry unit.
// Assumes: CSR selector is two bits wide; all other widths come from parameters.
package irq_pkg;

    // CSR selector values seen on csr_addr
    typedef enum logic [1:0] {
        SEL_ENABLE  = 2'd0,
        SEL_MASK    = 2'd1,
        SEL_PENDING = 2'd2,
        SEL_BASE    = 2'd3
    } csr_sel_e;

    // Width of the enable register: bit 0 live, bit 1 saved
    localparam int ENABLE_W = 2;

    // Pattern loaded into the enable register on entry
    localparam logic [ENABLE_W-1:0] ENABLE_ON_ENTRY = 2'b10;

endpackage

// File: rtl/irq_pending_bank.sv
// Sticky pending register with write-one-to-clear.
// Does: sets bit n whenever line n is high at a clock edge; clears bits
//       selected by a software clear mask unless the line is high again.
// Assumes: lines are already synchronous to clk.
module irq_pending_bank #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines,
    input  logic                 clr_en,
    input  logic [NUM_LINES-1:0] clr_mask,
    output logic [NUM_LINES-1:0] pend_q
);

    // One flop per line, set-over-clear priority
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_bit
        // Purpose: hold the sticky pending state of line g
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
            end else if (lines[g]) begin
                pend_q[g] <= 1'b1;
            end else if (clr_en && clr_mask[g]) begin
                pend_q[g] <= 1'b0;
            end
        end
    end

    AST_LINE_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (|lines) |=> ((pend_q & $past(lines)) == $past(lines)));          // R2

    AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> (($past(pend_q) & ~pend_q) == '0));                  // R2

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((pend_q & $past(clr_mask & ~lines)) == '0));          // R3

endmodule

// File: rtl/irq_csr_file.sv
// Enable, mask and base registers of the interrupt unit.
// Does: CSR writes to enable, mask and base; loads the entry pattern into
//       the enable register on entry, which beats a same-cycle write.
// Assumes: at most one CSR write per cycle; base alignment is a parameter.
module irq_csr_file
    import irq_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int XLEN       = 32,
    parameter int BASE_ALIGN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  csr_sel_e             wr_sel,
    input  logic [XLEN-1:0]      wr_data,
    input  logic                 entry_fire,
    output logic [ENABLE_W-1:0]  enable_q,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [XLEN-1:0]      base_q
);

    localparam logic [XLEN-1:0] BASE_KEEP = ~((XLEN'(1) << BASE_ALIGN) - XLEN'(1));

    // Purpose: enable register, entry pattern has priority over software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (entry_fire) begin
            enable_q <= ENABLE_ON_ENTRY;
        end else if (wr_en && wr_sel == SEL_ENABLE) begin
            enable_q <= wr_data[ENABLE_W-1:0];
        end
    end

    // Purpose: mask register, one bit per line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && wr_sel == SEL_MASK) begin
            mask_q <= wr_data[NUM_LINES-1:0];
        end
    end

    // Purpose: exception base register with forced alignment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en && wr_sel == SEL_BASE) begin
            base_q <= wr_data & BASE_KEEP;
        end
    end

    AST_ENTRY_ENABLE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        entry_fire |=> (enable_q == ENABLE_ON_ENTRY));                   // R8

endmodule

// File: rtl/irq_entry_ctrl.sv
// Serviceability check and entry outputs.
// Does: at a retired-instruction boundary, combines live enable, mask and
//       pending; drives the entry pulse, vector and return address.
// Assumes: the core redirects its PC in the same cycle the pulse is high.
module irq_entry_ctrl #(
    parameter int NUM_LINES  = 32,
    parameter int XLEN       = 32,
    parameter int EXC_ID     = 6,
    parameter int SLOT_BYTES = 32
) (
    input  logic                 live_enable,
    input  logic [NUM_LINES-1:0] mask,
    input  logic [NUM_LINES-1:0] pending,
    input  logic [XLEN-1:0]      base,
    input  logic                 retire,
    input  logic [XLEN-1:0]      pc_now,
    output logic                 fire,
    output logic [XLEN-1:0]      target,
    output logic                 save_ret,
    output logic [XLEN-1:0]      ret_value
);

    localparam logic [XLEN-1:0] VEC_OFFSET = XLEN'(EXC_ID * SLOT_BYTES);

    logic [NUM_LINES-1:0] hit;

    // Purpose: find any pending line that software has unmasked
    always_comb begin
        hit = mask & pending;
    end

    // Purpose: decide entry and form the redirect and return values
    always_comb begin
        fire      = retire && live_enable && (|hit);
        target    = base + VEC_OFFSET;
        save_ret  = fire;
        ret_value = pc_now;
    end

endmodule

// File: rtl/irq_entry_unit.sv
// Top of the interrupt pending and exception entry unit.
// Does: wires the pending bank, CSR file and entry check, and provides a
//       combinational CSR read port.
// Assumes: NUM_LINES <= XLEN; synchronous active-low reset.
module irq_entry_unit
    import irq_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int XLEN       = 32,
    parameter int EXC_ID     = 6,
    parameter int SLOT_BYTES = 32,
    parameter int BASE_ALIGN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 csr_we,
    input  logic [1:0]           csr_addr,
    input  logic [XLEN-1:0]      csr_wdata,
    output logic [XLEN-1:0]      csr_rdata,
    input  logic                 instr_retire,
    input  logic [XLEN-1:0]      cur_pc,
    output logic                 take_interrupt,
    output logic [XLEN-1:0]      vector_pc,
    output logic                 save_pc_to_r30,
    output logic [XLEN-1:0]      ret_pc
);

    csr_sel_e             sel;
    logic [ENABLE_W-1:0]  enable_q;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] pend_q;
    logic [XLEN-1:0]      base_q;
    logic                 pend_clr;

    // Purpose: decode the selector and the pending clear strobe
    always_comb begin
        sel      = csr_sel_e'(csr_addr);
        pend_clr = csr_we && (sel == SEL_PENDING);
    end

    irq_pending_bank #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (irq_lines),
        .clr_en   (pend_clr),
        .clr_mask (csr_wdata[NUM_LINES-1:0]),
        .pend_q   (pend_q)
    );

    irq_csr_file #(
        .NUM_LINES  (NUM_LINES),
        .XLEN       (XLEN),
        .BASE_ALIGN (BASE_ALIGN)
    ) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (csr_we),
        .wr_sel     (sel),
        .wr_data    (csr_wdata),
        .entry_fire (take_interrupt),
        .enable_q   (enable_q),
        .mask_q     (mask_q),
        .base_q     (base_q)
    );

    irq_entry_ctrl #(
        .NUM_LINES  (NUM_LINES),
        .XLEN       (XLEN),
        .EXC_ID     (EXC_ID),
        .SLOT_BYTES (SLOT_BYTES)
    ) u_ctrl (
        .live_enable (enable_q[0]),
        .mask        (mask_q),
        .pending     (pend_q),
        .base        (base_q),
        .retire      (instr_retire),
        .pc_now      (cur_pc),
        .fire        (take_interrupt),
        .target      (vector_pc),
        .save_ret    (save_pc_to_r30),
        .ret_value   (ret_pc)
    );

    // Purpose: CSR read multiplexer, zero-extending narrow registers
    always_comb begin
        unique case (sel)
            SEL_ENABLE:  csr_rdata = XLEN'(enable_q);
            SEL_MASK:    csr_rdata = XLEN'(mask_q);
            SEL_PENDING: csr_rdata = XLEN'(pend_q);
            SEL_BASE:    csr_rdata = base_q;
            default:     csr_rdata = '0;
        endcase
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        take_interrupt |=> !take_interrupt);                              // R10

    AST_NO_ENTRY_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (take_interrupt && !$past(take_interrupt)) |-> (enable_q == 2'b01 || enable_q == 2'b11)); // R4

endmodule

// File: tb/irq_entry_unit_bench.sv
module irq_entry_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_lines;
    logic        csr_we;
    logic [1:0]  csr_addr;
    logic [31:0] csr_wdata;
    logic [31:0] csr_rdata;
    logic        instr_retire;
    logic [31:0] cur_pc;
    logic        take_interrupt;
    logic [31:0] vector_pc;
    logic        save_pc_to_r30;
    logic [31:0] ret_pc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    irq_entry_unit u_irq_entry_unit (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .instr_retire(instr_retire), .cur_pc(cur_pc),
        .take_interrupt(take_interrupt), .vector_pc(vector_pc),
        .save_pc_to_r30(save_pc_to_r30), .ret_pc(ret_pc)
    );

    typedef struct packed {
        logic [31:0] mask;
        logic [31:0] base_w;
        logic [31:0] lines;
        logic [31:0] pc;
        logic        exp_take;
        logic [31:0] exp_vec;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{32'h0000_0001, 32'h0000_1000, 32'h0000_0001, 32'h0000_0400, 1'b1, 32'h0000_10C0},
        '{32'h8000_0000, 32'hABCD_12FF, 32'h8000_0000, 32'h0000_2004, 1'b1, 32'hABCD_12C0},
        '{32'h0000_00F0, 32'h0000_4000, 32'h0000_0008, 32'h0000_3000, 1'b0, 32'h0000_40C0},
        '{32'hFFFF_0000, 32'h0000_0000, 32'h0001_0001, 32'h0000_0100, 1'b1, 32'h0000_00C0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_lines = '0; csr_we = 1'b0; csr_addr = '0;
        csr_wdata = '0; instr_retire = 1'b0; cur_pc = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0; csr_wdata = '0;
    endtask

    task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic pulse_lines(input logic [31:0] l);
        @(negedge clk);
        irq_lines = l;
        @(negedge clk);
        irq_lines = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; irq_lines = '0; csr_we = 1'b0; csr_addr = '0;
        csr_wdata = '0; instr_retire = 1'b0; cur_pc = '0;

        // R1: reset state
        do_reset();
        for (int a = 0; a < 4; a++) begin
            csr_read(2'(a), rd);
            check("R1 reset csr", rd, 32'h0);
        end
        check("R1 reset take", {31'b0, take_interrupt}, 32'h0);

        // Table walk: R4 R6 R7 R8
        foreach (VECS[i]) begin
            do_reset();
            csr_write(2'd3, VECS[i].base_w);
            csr_write(2'd1, VECS[i].mask);
            pulse_lines(VECS[i].lines);
            csr_write(2'd0, 32'h1);
            @(negedge clk);
            instr_retire = 1'b1; cur_pc = VECS[i].pc;
            #1;
            check("R4 table take", {31'b0, take_interrupt}, {31'b0, VECS[i].exp_take});
            if (VECS[i].exp_take) begin
                check("R6 table vector", vector_pc, VECS[i].exp_vec);
                check("R7 table save", {31'b0, save_pc_to_r30}, 32'h1);
                check("R7 table ret", ret_pc, VECS[i].pc);
            end
            @(negedge clk);
            instr_retire = 1'b0;
            csr_read(2'd0, rd);
            check("R8 table enable", rd, VECS[i].exp_take ? 32'h2 : 32'h1);
            csr_read(2'd3, rd);
            check("R6 base aligned", rd, VECS[i].base_w & 32'hFFFF_FF00);
        end

        // R2: sticky pending
        do_reset();
        pulse_lines(32'h0000_0020);
        repeat (3) @(negedge clk);
        csr_read(2'd2, rd);
        check("R2 sticky", rd, 32'h0000_0020);

        // R3: write-one-to-clear, other bits kept
        pulse_lines(32'h0000_0100);
        csr_write(2'd2, 32'h0000_0020);
        csr_read(2'd2, rd);
        check("R3 w1c", rd, 32'h0000_0100);

        // R3: set beats clear when line still high
        @(negedge clk);
        irq_lines = 32'h0000_0080;
        csr_we = 1'b1; csr_addr = 2'd2; csr_wdata = 32'h0000_0080;
        @(negedge clk);
        csr_we = 1'b0; irq_lines = '0;
        csr_read(2'd2, rd);
        check("R3 set priority", rd, 32'h0000_0180);

        // R5: no entry without retire
        do_reset();
        csr_write(2'd1, 32'h1);
        pulse_lines(32'h1);
        csr_write(2'd0, 32'h1);
        @(negedge clk);
        #1 check("R5 no retire", {31'b0, take_interrupt}, 32'h0);
        // R10: retire held two cycles gives one pulse
        @(negedge clk);
        instr_retire = 1'b1; cur_pc = 32'h0000_0800;
        #1 check("R5 first retire", {31'b0, take_interrupt}, 32'h1);
        @(negedge clk);
        #1 check("R10 second cycle", {31'b0, take_interrupt}, 32'h0);
        instr_retire = 1'b0;

        // R8: entry beats same-cycle enable write
        do_reset();
        csr_write(2'd1, 32'h4);
        pulse_lines(32'h4);
        csr_write(2'd0, 32'h1);
        @(negedge clk);
        instr_retire = 1'b1;
        csr_we = 1'b1; csr_addr = 2'd0; csr_wdata = 32'h3;
        #1 check("R8 pulse with write", {31'b0, take_interrupt}, 32'h1);
        @(negedge clk);
        instr_retire = 1'b0; csr_we = 1'b0;
        csr_read(2'd0, rd);
        check("R8 entry priority", rd, 32'h2);

        // R9: line lowered before enable still enters later
        do_reset();
        pulse_lines(32'h0000_0400);
        repeat (4) @(negedge clk);
        @(negedge clk);
        instr_retire = 1'b1;
        #1 check("R9 not yet enabled", {31'b0, take_interrupt}, 32'h0);
        instr_retire = 1'b0;
        csr_write(2'd1, 32'h0000_0400);
        csr_write(2'd0, 32'h1);
        @(negedge clk);
        instr_retire = 1'b1; cur_pc = 32'h0000_0A00;
        #1 check("R9 late entry", {31'b0, take_interrupt}, 32'h1);
        check("R9 ret", ret_pc, 32'h0000_0A00);
        @(negedge clk);
        instr_retire = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule